// File: doc/BRIEF.md
# Register-Mapped SPI Master with Byte Queues

This block is a SPI master controller reached through a simple 32-bit register port. Software queues bytes in a transmit queue; a shift engine sends each byte over a serial clock and data-out line and, in the same transfer, gathers one byte from the data-in line into a receive queue. A control bit can hold transfers back, so that a whole message is queued first and then sent as one uninterrupted stream when the bit is cleared. A slave-select register drives one or more active-low chip selects directly.

Two single-cycle event outputs feed an external interrupt controller. One reports a received byte that was lost because the receive queue was full. The other reports that the transmit queue has run dry at the end of a byte. Each queue holds `FIFO_DEPTH` bytes, which must be a power of two. The serial clock runs at the system clock divided by the even parameter `CLK_DIV`.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, status reads 0x5, control reads 0, slave select reads all ones in its low `NUM_SEL` bits, both occupancy registers read 0 and every `cs_n` line is high.
- R2: A write of exactly 0x0000000A to offset 0x40 returns all registers and both queues to their reset state and ends any transfer in progress. A write of any other value to 0x40 leaves all state unchanged.
- R3: Control lives at offset 0x60. A write with bit 5 set empties the transmit queue, and a write with bit 6 set empties the receive queue. Bits 5 and 6 always read back as 0. All other written bits are stored and read back.
- R4: While control bit 8 is 1, no new byte starts and `sclk` stays low. Once the bit is 0, every queued transmit byte is sent, each one starting in the cycle the previous one ends.
- R5: Status is read at offset 0x64: bit 0 is receive empty, bit 1 receive full, bit 2 transmit empty and bit 3 transmit full, with all other bits 0. Writes to 0x64 have no effect.
- R6: A write to offset 0x68 queues bits 7:0 of the written data and ignores the rest. A write when the transmit queue is full is dropped. Offsets 0x74 and 0x78 read the transmit and receive entry counts.
- R7: Transfers use SPI mode 0, MSB first. `sclk` idles low and makes 8 rising edges per byte, each period lasting `CLK_DIV` clocks. `mosi` is stable at every rising edge, and `miso` is sampled on the rising edge.
- R8: Every byte sent yields exactly one received byte. If the receive queue is full at that moment, the byte is discarded, the queue is left unchanged and `ev_rx_overrun` pulses for one cycle.
- R9: A read at offset 0x6C returns the oldest received byte, zero-extended, and removes it. When the receive queue is empty, the read returns 0xDEADBEEF and changes nothing.
- R10: Slave select lives at offset 0x70. Writes store the low `NUM_SEL` bits, reads return them with all higher bits 0, and `cs_n[i]` equals bit i (0 selects). The outputs change only after a write to 0x70 or a soft reset.
- R11: `ev_tx_drained` pulses for one cycle when a byte finishes and the transmit queue is empty.
- R12: Every read request gives `bus_rvalid` high in the next cycle, with the data on `bus_rdata`. Unmapped offsets read 0 and ignore writes.
- R13: A receive-data read that lands in the cycle a byte completes both removes the oldest entry and appends the new byte, so the count is unchanged and the order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request, one cycle per access |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | 32 | Read data |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NUM_SEL | Active-low chip selects |
| ev_rx_overrun | output | 1 | Pulse: received byte dropped on a full receive queue |
| ev_tx_drained | output | 1 | Pulse: byte done with the transmit queue empty |

## Verification
The receive queue has two sources of change that can act in the same cycle: the software read that pops its head, and the end of a serial byte that pushes onto its tail. To provoke the overlap, the bench starts a stream with two bytes already waiting, then reads once every 17 cycles (the byte time with a divider of two). It sweeps the start offset of these reads over all 17 phases, so that in some runs a pop falls exactly on a completion cycle. Each run is judged on two things: the bytes read back must equal the inverted sent bytes in order, and the receive occupancy must be zero at the end. A checker property also requires the count to hold steady in any cycle where a pop and a push both take effect.

// File: rtl/spi_fm_pkg.sv
`timescale 1ns/1ps
package spi_fm_pkg;
  localparam int WORD_W = 32;

  localparam logic [7:0] OFS_SRST  = 8'h40;
  localparam logic [7:0] OFS_CTRL  = 8'h60;
  localparam logic [7:0] OFS_STAT  = 8'h64;
  localparam logic [7:0] OFS_TXD   = 8'h68;
  localparam logic [7:0] OFS_RXD   = 8'h6C;
  localparam logic [7:0] OFS_SSEL  = 8'h70;
  localparam logic [7:0] OFS_TXOCC = 8'h74;
  localparam logic [7:0] OFS_RXOCC = 8'h78;

  localparam logic [WORD_W-1:0] SRST_KEY   = 32'h0000_000A;
  localparam logic [WORD_W-1:0] EMPTY_MARK = 32'hDEAD_BEEF;

  localparam int CTRL_TXCLR_BIT = 5;
  localparam int CTRL_RXCLR_BIT = 6;
  localparam int CTRL_HOLD_BIT  = 8;

  // control value as stored: the two queue-clear strobes are never kept
  function automatic logic [WORD_W-1:0] ctrl_store(input logic [WORD_W-1:0] wr);
    logic [WORD_W-1:0] v;
    v = wr;
    v[CTRL_TXCLR_BIT] = 1'b0;
    v[CTRL_RXCLR_BIT] = 1'b0;
    return v;
  endfunction

  // status word from queue flags
  function automatic logic [WORD_W-1:0] status_word(input logic rx_e, input logic rx_f,
                                                    input logic tx_e, input logic tx_f);
    return {{(WORD_W-4){1'b0}}, tx_f, tx_e, rx_f, rx_e};
  endfunction

  // next entry count of a queue
  function automatic logic [15:0] next_count(input logic [15:0] cur, input logic inc,
                                             input logic dec);
    return cur + {15'd0, inc} - {15'd0, dec};
  endfunction
endpackage

// File: rtl/spi_byte_fifo.sv
`timescale 1ns/1ps
module spi_byte_fifo #(
  parameter int DEPTH = 256,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  import spi_fm_pkg::*;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;
  logic [15:0]   cnt_nxt;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];
  assign cnt_nxt = next_count(16'(count), do_push, do_pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      count <= cnt_nxt[CW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_ptr] <= wdata;
  end
endmodule

// File: rtl/spi_mode0_shifter.sv
`timescale 1ns/1ps
module spi_mode0_shifter #(
  parameter int CLK_DIV = 4,
  localparam int HALF   = CLK_DIV / 2,
  localparam int DW     = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       busy,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx_byte
);
  logic [7:0]    tx_sh, rx_sh;
  logic [2:0]    bit_cnt;
  logic [DW-1:0] div_cnt;
  logic          half_tick;

  assign half_tick = (div_cnt == DW'(HALF - 1));
  assign mosi      = tx_sh[7];
  assign rx_byte   = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sclk    <= 1'b0;
      done    <= 1'b0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      bit_cnt <= '0;
      div_cnt <= '0;
    end else if (abort) begin
      busy    <= 1'b0;
      sclk    <= 1'b0;
      done    <= 1'b0;
      bit_cnt <= '0;
      div_cnt <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy    <= 1'b1;
        tx_sh   <= tx_byte;
        bit_cnt <= '0;
        div_cnt <= '0;
        sclk    <= 1'b0;
      end else if (busy) begin
        if (half_tick) begin
          div_cnt <= '0;
          if (!sclk) begin
            sclk  <= 1'b1;
            rx_sh <= {rx_sh[6:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bit_cnt == 3'd7) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              bit_cnt <= bit_cnt + 3'd1;
              tx_sh   <= {tx_sh[6:0], 1'b0};
            end
          end
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_fifo_master.sv
`timescale 1ns/1ps
module spi_fifo_master
  import spi_fm_pkg::*;
#(
  parameter int FIFO_DEPTH = 256,
  parameter int NUM_SEL    = 1,
  parameter int CLK_DIV    = 4,
  parameter int ADDR_W     = 8,
  localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic              bus_rvalid,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_SEL-1:0] cs_n,
  output logic              ev_rx_overrun,
  output logic              ev_tx_drained
);
  // register decode
  logic wr_req, rd_req;
  logic soft_rst, ctrl_wr, txd_wr, ssel_wr, rxd_rd;
  assign wr_req   = bus_valid && bus_write;
  assign rd_req   = bus_valid && !bus_write;
  assign soft_rst = wr_req && (bus_addr == ADDR_W'(OFS_SRST)) && (bus_wdata == SRST_KEY);
  assign ctrl_wr  = wr_req && (bus_addr == ADDR_W'(OFS_CTRL));
  assign txd_wr   = wr_req && (bus_addr == ADDR_W'(OFS_TXD));
  assign ssel_wr  = wr_req && (bus_addr == ADDR_W'(OFS_SSEL));
  assign rxd_rd   = rd_req && (bus_addr == ADDR_W'(OFS_RXD));

  // control and slave-select state
  logic [WORD_W-1:0]  ctrl_q;
  logic [NUM_SEL-1:0] ssel_q;
  logic               inhibit;
  assign inhibit = ctrl_q[CTRL_HOLD_BIT];
  assign cs_n    = ssel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ssel_q <= '1;
    end else if (soft_rst) begin
      ctrl_q <= '0;
      ssel_q <= '1;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_store(bus_wdata);
      if (ssel_wr) ssel_q <= bus_wdata[NUM_SEL-1:0];
    end
  end

  // queues
  logic             tx_clr, rx_clr;
  logic [7:0]       tx_head, rx_head;
  logic [CNT_W-1:0] tx_count, rx_count;
  logic             tx_empty, tx_full, rx_empty, rx_full;
  logic             sh_busy, sh_done, sh_start;
  logic [7:0]       sh_rx_byte;

  assign tx_clr = soft_rst || (ctrl_wr && bus_wdata[CTRL_TXCLR_BIT]);
  assign rx_clr = soft_rst || (ctrl_wr && bus_wdata[CTRL_RXCLR_BIT]);

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) tx_q (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr),
    .push(txd_wr), .wdata(bus_wdata[7:0]),
    .pop(sh_start), .rdata(tx_head),
    .count(tx_count), .empty(tx_empty), .full(tx_full)
  );

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) rx_q (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr),
    .push(sh_done), .wdata(sh_rx_byte),
    .pop(rxd_rd), .rdata(rx_head),
    .count(rx_count), .empty(rx_empty), .full(rx_full)
  );

  // shift engine
  assign sh_start = !sh_busy && !inhibit && !tx_empty && !tx_clr;

  spi_mode0_shifter #(.CLK_DIV(CLK_DIV)) shifter (
    .clk(clk), .rst_n(rst_n), .abort(soft_rst),
    .start(sh_start), .tx_byte(tx_head), .miso(miso),
    .busy(sh_busy), .sclk(sclk), .mosi(mosi),
    .done(sh_done), .rx_byte(sh_rx_byte)
  );

  assign ev_rx_overrun = sh_done && rx_full;
  assign ev_tx_drained = sh_done && tx_empty;

  // read path
  logic [WORD_W-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    if (bus_addr == ADDR_W'(OFS_CTRL))       rd_word = ctrl_q;
    else if (bus_addr == ADDR_W'(OFS_STAT))  rd_word = status_word(rx_empty, rx_full, tx_empty, tx_full);
    else if (bus_addr == ADDR_W'(OFS_RXD))   rd_word = rx_empty ? EMPTY_MARK : {24'd0, rx_head};
    else if (bus_addr == ADDR_W'(OFS_SSEL))  rd_word = WORD_W'(ssel_q);
    else if (bus_addr == ADDR_W'(OFS_TXOCC)) rd_word = WORD_W'(tx_count);
    else if (bus_addr == ADDR_W'(OFS_RXOCC)) rd_word = WORD_W'(rx_count);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_req;
      if (rd_req) bus_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/spi_fifo_master_chk.sv
`timescale 1ns/1ps
module spi_fifo_master_chk
  import spi_fm_pkg::*;
#(
  parameter int FIFO_DEPTH = 256,
  parameter int NUM_SEL    = 1,
  parameter int ADDR_W     = 8,
  parameter int CNT_W      = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rvalid,
  input logic [WORD_W-1:0] bus_rdata,
  input logic              sclk,
  input logic [NUM_SEL-1:0] cs_n,
  input logic              ev_rx_overrun,
  input logic              ev_tx_drained,
  input logic              soft_rst,
  input logic              ssel_wr,
  input logic              rxd_rd,
  input logic              inhibit,
  input logic              sh_busy,
  input logic              sh_done,
  input logic              rx_full,
  input logic              rx_empty,
  input logic              rx_clr,
  input logic              tx_empty,
  input logic [CNT_W-1:0]  tx_count,
  input logic [CNT_W-1:0]  rx_count
);
  assert_cs_write_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cs_n) |-> $past(ssel_wr || soft_rst));

  assert_sclk_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_busy |-> !sclk);

  assert_hold_blocks_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && !sh_busy) |=> !sh_busy);

  assert_overrun_on_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_overrun |-> rx_full);

  assert_drained_when_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_drained |-> tx_empty);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count <= CNT_W'(FIFO_DEPTH)) && (rx_count <= CNT_W'(FIFO_DEPTH)));

  assert_ctrl_strobes_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr == ADDR_W'(OFS_CTRL)) |=> (bus_rdata[6:5] == 2'b00));

  assert_empty_marker_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rxd_rd && rx_empty) |=> (bus_rdata == EMPTY_MARK));

  assert_read_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> bus_rvalid);

  assert_dual_access_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (rxd_rd && sh_done && !rx_full && !rx_empty && !rx_clr) |=> $stable(rx_count));
endmodule

bind spi_fifo_master spi_fifo_master_chk #(
  .FIFO_DEPTH(FIFO_DEPTH), .NUM_SEL(NUM_SEL), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
  .sclk(sclk), .cs_n(cs_n), .ev_rx_overrun(ev_rx_overrun),
  .ev_tx_drained(ev_tx_drained), .soft_rst(soft_rst), .ssel_wr(ssel_wr),
  .rxd_rd(rxd_rd), .inhibit(inhibit), .sh_busy(sh_busy), .sh_done(sh_done),
  .rx_full(rx_full), .rx_empty(rx_empty), .rx_clr(rx_clr), .tx_empty(tx_empty),
  .tx_count(tx_count), .rx_count(rx_count)
);

// File: tb/spi_fifo_master_tb_top.sv
`timescale 1ns/1ps
module spi_fifo_master_tb_top;
  localparam int DEPTH = 8;
  localparam int NSEL  = 3;
  localparam int DIV   = 2;
  localparam int BYTE_T = 8 * DIV + 1;

  localparam logic [7:0] A_SRST = 8'h40, A_CTRL = 8'h60, A_STAT = 8'h64, A_TXD = 8'h68,
                         A_RXD = 8'h6C, A_SSEL = 8'h70, A_TXOCC = 8'h74, A_RXOCC = 8'h78;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic        sclk, mosi, miso;
  logic [NSEL-1:0] cs_n;
  logic        ev_rx_overrun, ev_tx_drained;

  int checks = 0;
  int fails  = 0;
  int ovr_cnt = 0, drain_cnt = 0, rises = 0, nlog = 0, bitn = 0;
  logic [7:0] cap = '0;
  logic [7:0] mosi_log [64];

  always #2 clk = ~clk;
  assign miso = ~mosi;

  spi_fifo_master #(.FIFO_DEPTH(DEPTH), .NUM_SEL(NSEL), .CLK_DIV(DIV), .ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n),
    .ev_rx_overrun(ev_rx_overrun), .ev_tx_drained(ev_tx_drained)
  );

  always @(negedge clk) begin
    if (ev_rx_overrun) ovr_cnt++;
    if (ev_tx_drained) drain_cnt++;
  end

  always @(posedge sclk) begin
    rises++;
    cap = {cap[6:0], mosi};
    bitn++;
    if (bitn == 8) begin
      if (nlog < 64) mosi_log[nlog] = cap;
      nlog++;
      bitn = 0;
    end
  end

  function automatic logic [7:0] pat(input int k);
    return 8'(8'h3C + k * 37);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
    check("R12 rvalid", {31'd0, bus_rvalid}, 32'd1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int lg0, r0;
    idle(5);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd(A_STAT, v);  check("R1 status", v, 32'h5);
    rd(A_CTRL, v);  check("R1 control", v, 32'h0);
    rd(A_SSEL, v);  check("R1 select", v, 32'h7);
    rd(A_TXOCC, v); check("R1 tx occ", v, 32'h0);
    rd(A_RXOCC, v); check("R1 rx occ", v, 32'h0);
    check("R1 cs_n", 32'(cs_n), 32'h7);
    rd(8'h10, v);   check("R12 unmapped", v, 32'h0);

    // R4 / R6: queue under hold
    wr(A_CTRL, 32'h100);
    for (int k = 0; k < DEPTH; k++) wr(A_TXD, {24'hABCDEF, pat(k)});
    rd(A_TXOCC, v); check("R6 tx occ full", v, DEPTH);
    rd(A_STAT, v);  check("R5 status tx full", v, 32'h9);
    wr(A_TXD, 32'hFF);
    rd(A_TXOCC, v); check("R6 drop on full", v, DEPTH);
    idle(40);
    check("R4 no shift under hold", nlog, 0);
    check("R4 sclk idle", {31'd0, sclk}, 32'd0);

    // R4 / R7 / R11: release
    wr(A_CTRL, 32'h0);
    idle(DEPTH * BYTE_T + 20);
    check("R4 all sent", nlog, DEPTH);
    check("R7 rising edges", rises, DEPTH * 8);
    for (int k = 0; k < DEPTH; k++) check("R7 mosi msb first", 32'(mosi_log[k]), 32'(pat(k)));
    check("R11 one drained pulse", drain_cnt, 1);
    rd(A_RXOCC, v); check("R8 rx occ", v, DEPTH);
    rd(A_STAT, v);  check("R5 status rx full tx empty", v, 32'h6);

    // R8 overrun
    wr(A_TXD, 32'h55);
    idle(BYTE_T + 10);
    check("R8 overrun pulse", ovr_cnt, 1);
    check("R11 second drained", drain_cnt, 2);
    rd(A_RXOCC, v); check("R8 rx occ unchanged", v, DEPTH);

    // R9 read out
    for (int k = 0; k < DEPTH; k++) begin
      rd(A_RXD, v); check("R9 rx data", v, {24'd0, ~pat(k)});
    end
    rd(A_RXD, v);   check("R9 empty marker", v, 32'hDEADBEEF);
    rd(A_RXOCC, v); check("R9 occ after empty read", v, 32'h0);
    rd(A_STAT, v);  check("R9 status after drain", v, 32'h5);

    // R5 status write ignored
    wr(A_STAT, 32'hF);
    rd(A_STAT, v);  check("R5 status write ignored", v, 32'h5);

    // R3 queue clear strobes
    wr(A_CTRL, 32'h100);
    wr(A_TXD, 32'h11); wr(A_TXD, 32'h22);
    wr(A_CTRL, 32'h0);
    idle(2 * BYTE_T + 10);
    rd(A_RXOCC, v); check("R3 rx filled", v, 32'h2);
    wr(A_CTRL, 32'h1040);
    rd(A_RXOCC, v); check("R3 rx cleared", v, 32'h0);
    rd(A_CTRL, v);  check("R3 rx strobe reads 0", v, 32'h1000);
    wr(A_CTRL, 32'h100);
    lg0 = nlog;
    wr(A_TXD, 32'h1); wr(A_TXD, 32'h2); wr(A_TXD, 32'h3);
    wr(A_CTRL, 32'h120);
    rd(A_TXOCC, v); check("R3 tx cleared", v, 32'h0);
    rd(A_CTRL, v);  check("R3 tx strobe reads 0", v, 32'h100);
    wr(A_CTRL, 32'h0);
    idle(BYTE_T + 10);
    check("R3 nothing sent after clear", nlog, lg0);

    // R10 select sweep
    for (int s = 0; s < (1 << NSEL); s++) begin
      wr(A_SSEL, 32'hFFFF_FFF8 | 32'(s));
      check("R10 cs_n", 32'(cs_n), 32'(s));
      rd(A_SSEL, v); check("R10 select read", v, 32'(s));
    end

    // R2 soft reset
    wr(A_SSEL, 32'h2);
    wr(A_SRST, 32'h5);
    rd(A_SSEL, v);  check("R2 wrong key ignored", v, 32'h2);
    wr(A_SRST, 32'h10A);
    rd(A_SSEL, v);  check("R2 near key ignored", v, 32'h2);
    wr(A_CTRL, 32'h100);
    wr(A_TXD, 32'h9); wr(A_TXD, 32'h8);
    wr(A_SRST, 32'hA);
    rd(A_SSEL, v);  check("R2 select reset", v, 32'h7);
    rd(A_CTRL, v);  check("R2 control reset", v, 32'h0);
    rd(A_TXOCC, v); check("R2 tx queue reset", v, 32'h0);
    rd(A_STAT, v);  check("R2 status reset", v, 32'h5);
    check("R2 cs_n", 32'(cs_n), 32'h7);

    // R13 pop and push in one cycle, phase sweep
    for (int ph = 0; ph < BYTE_T; ph++) begin
      r0 = 0;
      wr(A_CTRL, 32'h100);
      for (int k = 0; k < 4; k++) wr(A_TXD, 32'(8'(ph * 16 + k * 5 + 1)));
      wr(A_CTRL, 32'h0);
      idle(2 * BYTE_T + 1 + ph);
      for (int k = 0; k < 4; k++) begin
        rd(A_RXD, v);
        if (v !== {24'd0, ~8'(ph * 16 + k * 5 + 1)}) r0++;
        idle(BYTE_T - 2);
      end
      check("R13 order kept", r0, 0);
      rd(A_RXOCC, v); check("R13 occ zero", v, 32'h0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule